// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is one output cell of a small sum-of-products programmable logic device. An external AND array supplies eight product terms. The cell combines them into an output value for the pad, an enable for the pad, and a feedback signal that goes back into the array. Two configuration bits are shared by every cell in the device and pick a global mode. Three further bits belong to each cell and select the register or combinational path, the output polarity, and the drive style.

In registered mode a cell is either a clocked output or a combinational I/O. A clocked output ORs all eight terms into a flip-flop. Its pad enable comes from a shared active-low output-enable pin. A combinational I/O ORs seven terms and uses the remaining term as its own pad enable. Complex mode makes every cell a combinational I/O. In that mode a cell placed at the edge of the array has no feedback path. Simple mode makes every cell a plain combinational output that is always enabled. Open-drain drive is emulated by releasing the pad whenever a logic 1 would be driven. The flip-flop is cleared at power-up and can be preloaded with any value through a synchronous load.

Top module: `logic_out_cell`

## Requirements
- R1: The global mode is decoded from {mode_sync_i, mode_ac0_i}: 2'b01 is registered, 2'b11 is complex, 2'b10 is simple. The code 2'b00 is reserved: it forces pad_oe_o=0 and fb_o=0.
- R2: In registered mode with cell_ac1_i=0, the flip-flop captures the OR of all eight terms, term_i[0] included, on each rising clock edge. pad_oe_o equals the inverse of oe_pin_n_i.
- R3: A combinational I/O is registered mode with cell_ac1_i=1, or complex mode. Its raw value is the OR of term_i[7:1], and pad_oe_o follows term_i[0] combinationally.
- R4: In simple mode the raw value is the OR of all eight terms and the cell is always enabled.
- R5: With cell_xor_i=1 the pad value equals the raw value (active high). With cell_xor_i=0 the pad value is the raw value inverted (active low). This holds in every mode.
- R6: With cell_ac2_i=1 the drive is totem-pole: pad_oe_o equals the enable and pad_o equals the pad value. With cell_ac2_i=0 the drive is open-drain: pad_o=0, and pad_oe_o=1 only when the cell is enabled and the pad value is 0.
- R7: A registered cell feeds back the inverted flip-flop output. The feedback does not depend on the output-enable pin, the polarity bit or the drive style.
- R8: A combinational I/O or a simple output feeds back pad_i. In complex mode a cell built with EDGE_CELL=1 feeds back 0.
- R9: While rst_n is low, and until the first capture after it is released, the flip-flop holds 0.
- R10: When preload_en_i is high at a rising edge, the flip-flop loads preload_val_i in any mode, whatever the terms are.
- R11: In complex mode cell_ac1_i has no effect on pad_o, pad_oe_o or fb_o.
- R12: When the cell is not a registered output and no preload is requested, the flip-flop keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared device clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| term_i | input | 8 | Product terms from the AND array; bit 0 is the per-cell enable term |
| oe_pin_n_i | input | 1 | Shared active-low output-enable pin |
| mode_sync_i | input | 1 | Global mode bit, high for complex or simple |
| mode_ac0_i | input | 1 | Global mode bit, high for registered or complex |
| cell_ac1_i | input | 1 | Per-cell: 0 registered output, 1 combinational I/O (registered mode only) |
| cell_xor_i | input | 1 | Per-cell polarity: 1 active high, 0 active low |
| cell_ac2_i | input | 1 | Per-cell drive: 1 totem-pole, 0 open-drain |
| preload_en_i | input | 1 | Synchronous preload request for the flip-flop |
| preload_val_i | input | 1 | Value loaded on preload |
| pad_i | input | 1 | Value present on the pad, used as combinational feedback |
| pad_o | output | 1 | Value driven onto the pad |
| pad_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback into the AND array |

## Verification
The assertions assume that the configuration bits and the terms change only between clock edges. They also assume that the flip-flop's next value is taken from the term OR, or from the preload value, at the edge where it is sampled. The bench changes every input on the falling clock edge. It samples combinational outputs within the same low phase and registered results just after the next rising edge, so each property sees a stable input in every cycle. An edge-cell instance shares the inputs so that the missing feedback path can be observed directly.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  typedef enum logic [1:0] {
    GMODE_RSVD    = 2'b00,
    GMODE_REG     = 2'b01,
    GMODE_SIMPLE  = 2'b10,
    GMODE_COMPLEX = 2'b11
  } gmode_e;

  typedef enum logic [1:0] {
    KIND_OFF,
    KIND_REG,
    KIND_CIO,
    KIND_SIMPLE
  } cell_kind_e;

  function automatic gmode_e decode_gmode(input logic syn, input logic ac0);
    gmode_e m;
    unique case ({syn, ac0})
      2'b01:   m = GMODE_REG;
      2'b11:   m = GMODE_COMPLEX;
      2'b10:   m = GMODE_SIMPLE;
      default: m = GMODE_RSVD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/olmc_rst_sync.sv
module olmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/olmc_term_sum.sv
module olmc_term_sum #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] terms,
  input  logic               use_oe_term,
  output logic               sum,
  output logic               oe_term
);
  localparam int OE_IDX = 0;

  logic [N_TERMS-1:0] masked;

  always_comb begin
    masked = terms;
    if (use_oe_term) masked[OE_IDX] = 1'b0;
    sum     = |masked;
    oe_term = terms[OE_IDX];
  end
endmodule

// File: rtl/olmc_flop.sv
module olmc_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic d,
  input  logic pre_en,
  input  logic pre_val,
  output logic q
);
  logic q_d;
  logic ce;

  always_comb begin
    ce  = cap_en | pre_en;
    q_d = pre_en ? pre_val : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (ce) q <= q_d;
  end

  AST_CAPTURE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !pre_en) |=> (q == $past(d)));  // R2
  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |=> (q == $past(pre_val)));  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !pre_en) |=> $stable(q));  // R12
endmodule

// File: rtl/olmc_pad_drive.sv
module olmc_pad_drive (
  input  logic raw,
  input  logic pol_high,
  input  logic enable,
  input  logic totem,
  output logic pad_o,
  output logic pad_oe
);
  logic val;

  always_comb begin
    val = pol_high ? raw : ~raw;
    if (totem) begin
      pad_o  = val;
      pad_oe = enable;
    end else begin
      pad_o  = 1'b0;
      pad_oe = enable & ~val;
    end
  end
endmodule

// File: rtl/logic_out_cell.sv
module logic_out_cell
  import olmc_pkg::*;
#(
  parameter int N_TERMS   = 8,
  parameter bit EDGE_CELL = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TERMS-1:0] term_i,
  input  logic               oe_pin_n_i,
  input  logic               mode_sync_i,
  input  logic               mode_ac0_i,
  input  logic               cell_ac1_i,
  input  logic               cell_xor_i,
  input  logic               cell_ac2_i,
  input  logic               preload_en_i,
  input  logic               preload_val_i,
  input  logic               pad_i,
  output logic               pad_o,
  output logic               pad_oe_o,
  output logic               fb_o
);
  gmode_e     gmode;
  cell_kind_e kind;
  logic       rst_n_sync;
  logic       sum;
  logic       oe_term;
  logic       q;
  logic       raw;
  logic       enable;
  logic       cap_en;

  olmc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    gmode = decode_gmode(mode_sync_i, mode_ac0_i);
    unique case (gmode)
      GMODE_REG:     kind = cell_ac1_i ? KIND_CIO : KIND_REG;
      GMODE_COMPLEX: kind = KIND_CIO;
      GMODE_SIMPLE:  kind = KIND_SIMPLE;
      default:       kind = KIND_OFF;
    endcase
    cap_en = (kind == KIND_REG);
  end

  olmc_term_sum #(.N_TERMS(N_TERMS)) u_sum (
    .terms       (term_i),
    .use_oe_term (kind == KIND_CIO),
    .sum         (sum),
    .oe_term     (oe_term)
  );

  olmc_flop u_ff (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .cap_en  (cap_en),
    .d       (sum),
    .pre_en  (preload_en_i),
    .pre_val (preload_val_i),
    .q       (q)
  );

  always_comb begin
    raw = (kind == KIND_REG) ? q : sum;
    unique case (kind)
      KIND_REG:    enable = ~oe_pin_n_i;
      KIND_CIO:    enable = oe_term;
      KIND_SIMPLE: enable = 1'b1;
      default:     enable = 1'b0;
    endcase
  end

  olmc_pad_drive u_pad (
    .raw      (raw),
    .pol_high (cell_xor_i),
    .enable   (enable),
    .totem    (cell_ac2_i),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe_o)
  );

  generate
    if (EDGE_CELL) begin : g_edge_fb
      always_comb begin
        unique case (kind)
          KIND_REG:    fb_o = ~q;
          KIND_CIO:    fb_o = (gmode == GMODE_COMPLEX) ? 1'b0 : pad_i;
          KIND_SIMPLE: fb_o = pad_i;
          default:     fb_o = 1'b0;
        endcase
      end
      AST_EDGE_NO_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (mode_sync_i && mode_ac0_i) |-> !fb_o);  // R8
    end else begin : g_inner_fb
      always_comb begin
        unique case (kind)
          KIND_REG:    fb_o = ~q;
          KIND_CIO,
          KIND_SIMPLE: fb_o = pad_i;
          default:     fb_o = 1'b0;
        endcase
      end
    end
  endgenerate

  AST_RSVD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!mode_sync_i && !mode_ac0_i) |-> (!pad_oe_o && !fb_o));  // R1
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!cell_ac2_i && pad_oe_o) |-> !pad_o);  // R6
  AST_SIMPLE_ON: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_sync_i && !mode_ac0_i && cell_ac2_i) |-> pad_oe_o);  // R4
  AST_REG_PIN_OE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!mode_sync_i && mode_ac0_i && !cell_ac1_i && cell_ac2_i) |-> (pad_oe_o == !oe_pin_n_i));  // R2
endmodule

// File: tb/logic_out_cell_tb_top.sv
module logic_out_cell_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] term;
  logic       oe_n, syn, ac0, ac1, xr, ac2, pre_en, pre_val, pad_in;
  logic       pad_o, pad_oe, fb;
  logic       e_pad_o, e_pad_oe, e_fb;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  logic_out_cell dut_i (
    .clk(clk), .rst_n(rst_n), .term_i(term), .oe_pin_n_i(oe_n),
    .mode_sync_i(syn), .mode_ac0_i(ac0), .cell_ac1_i(ac1), .cell_xor_i(xr),
    .cell_ac2_i(ac2), .preload_en_i(pre_en), .preload_val_i(pre_val),
    .pad_i(pad_in), .pad_o(pad_o), .pad_oe_o(pad_oe), .fb_o(fb)
  );

  logic_out_cell #(.EDGE_CELL(1'b1)) dut_edge_i (
    .clk(clk), .rst_n(rst_n), .term_i(term), .oe_pin_n_i(oe_n),
    .mode_sync_i(syn), .mode_ac0_i(ac0), .cell_ac1_i(ac1), .cell_xor_i(xr),
    .cell_ac2_i(ac2), .preload_en_i(pre_en), .preload_val_i(pre_val),
    .pad_i(pad_in), .pad_o(e_pad_o), .pad_oe_o(e_pad_oe), .fb_o(e_fb)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg(input logic s, input logic a0, input logic a1,
                     input logic x, input logic a2);
    syn = s; ac0 = a0; ac1 = a1; xr = x; ac2 = a2;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic edge_then_sample();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; term = 8'hFF; oe_n = 1'b0; pre_en = 1'b0; pre_val = 1'b0; pad_in = 1'b0;
    cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset pad_o", pad_o, 1'b0);
    check("R9 reset fb", fb, 1'b1);
    @(negedge clk); rst_n = 1'b1; term = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 after release pad_o", pad_o, 1'b0);
    check("R2 pin enable", pad_oe, 1'b1);
  endtask

  task automatic t_registered();
    @(negedge clk); cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1); term = 8'h80;
    settle();
    check("R2 no capture before edge", pad_o, 1'b0);
    edge_then_sample();
    check("R2 term7 captured", pad_o, 1'b1);
    check("R7 fb is inverted q", fb, 1'b0);
    @(negedge clk); term = 8'h00; edge_then_sample();
    check("R2 cleared", pad_o, 1'b0);
    @(negedge clk); term = 8'h01; edge_then_sample();
    check("R2 term0 included", pad_o, 1'b1);
    @(negedge clk); oe_n = 1'b1; settle();
    check("R2 pin disables", pad_oe, 1'b0);
    check("R7 fb with pin off", fb, 1'b0);
    @(negedge clk); xr = 1'b0; settle();
    check("R7 fb with active low", fb, 1'b0);
    @(negedge clk); oe_n = 1'b0; settle();
    check("R5 reg active low", pad_o, 1'b0);
  endtask

  task automatic t_comb_io();
    @(negedge clk); cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1); term = 8'h02; pad_in = 1'b1; settle();
    check("R3 oe term low", pad_oe, 1'b0);
    check("R8 fb from pad 1", fb, 1'b1);
    @(negedge clk); term = 8'h03; pad_in = 1'b0; settle();
    check("R3 oe term high", pad_oe, 1'b1);
    check("R3 sum high", pad_o, 1'b1);
    check("R8 fb from pad 0", fb, 1'b0);
    @(negedge clk); term = 8'h01; settle();
    check("R3 term0 not in sum", pad_o, 1'b0);
    check("R3 enabled by term0", pad_oe, 1'b1);
  endtask

  task automatic t_complex();
    for (int a1 = 0; a1 < 2; a1++) begin
      @(negedge clk); cfg(1'b1, 1'b1, a1[0], 1'b1, 1'b1); term = 8'h05; pad_in = 1'b1; settle();
      check("R11 complex pad_o", pad_o, 1'b1);
      check("R11 complex pad_oe", pad_oe, 1'b1);
      check("R11 complex fb", fb, 1'b1);
      check("R8 edge cell fb", e_fb, 1'b0);
    end
    @(negedge clk); term = 8'h04; settle();
    check("R3 complex oe term", pad_oe, 1'b0);
  endtask

  task automatic t_simple();
    @(negedge clk); cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b1); term = 8'h01; pad_in = 1'b0; settle();
    check("R4 simple term0 in sum", pad_o, 1'b1);
    check("R4 simple enabled", pad_oe, 1'b1);
    check("R8 simple fb", fb, 1'b0);
    check("R8 edge simple fb", e_fb, 1'b0);
    @(negedge clk); term = 8'h00; settle();
    check("R4 simple low", pad_o, 1'b0);
    check("R4 simple enabled low", pad_oe, 1'b1);
    @(negedge clk); xr = 1'b0; settle();
    check("R5 simple inverted", pad_o, 1'b1);
  endtask

  task automatic t_open_drain();
    @(negedge clk); cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b0); term = 8'h00; settle();
    check("R6 od drives low", pad_oe, 1'b1);
    check("R6 od value", pad_o, 1'b0);
    @(negedge clk); term = 8'h10; settle();
    check("R6 od releases one", pad_oe, 1'b0);
    @(negedge clk); xr = 1'b0; settle();
    check("R6 od active low drives", pad_oe, 1'b1);
  endtask

  task automatic t_reserved();
    @(negedge clk); cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1); term = 8'hFF; pad_in = 1'b1; settle();
    check("R1 reserved oe", pad_oe, 1'b0);
    check("R1 reserved fb", fb, 1'b0);
  endtask

  task automatic t_preload_hold();
    @(negedge clk); cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1); term = 8'h00; oe_n = 1'b0;
    pre_en = 1'b1; pre_val = 1'b1; edge_then_sample();
    check("R10 preload one over zero terms", pad_o, 1'b1);
    @(negedge clk); cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b1); pre_val = 1'b0; edge_then_sample();
    @(negedge clk); pre_en = 1'b0; cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1); settle();
    check("R10 preload zero in simple mode", pad_o, 1'b0);
    @(negedge clk); pre_en = 1'b1; pre_val = 1'b1; edge_then_sample();
    @(negedge clk); pre_en = 1'b0; cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b1); term = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1); settle();
    check("R12 held through complex", fb, 1'b0);
    check("R12 held value", pad_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_registered();
    t_comb_io();
    t_complex();
    t_simple();
    t_open_drain();
    t_reserved();
    t_preload_hold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule